// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block is a bank of independent interval timers reached through a plain 32-bit register bus with separate read and write strobes. A single input tick feeds two shared prescalers, each programmed with its own 8-bit ratio and its own enable. Every channel picks one of the two prescalers and counts its pulses. When the count matches the channel's target, the channel flags an event. The channel then either stops, which is single-shot use, or restarts from its own reload value, which is auto-repeat use.

Event flags gather into one status register whose bits are cleared by writing ones. Two masks gate the flags onto a single interrupt line: a global enable mask and a routing mask. Software typically programs the target and reload values first, then selects a prescaler and mode and sets the enable bit. Its interrupt handler clears the status bit of the channel that fired. The register bus is a control path with no back-pressure: every access completes in one cycle, and read data appears on the cycle after the read strobe.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The prescaler register is at 0x30. Field [7:0] holds ratio A, field [15:8] holds ratio B, bit 16 enables prescaler A and bit 17 enables prescaler B. An enabled prescaler with field value d emits one pulse per d+1 input ticks, counted from the write that enabled it. A disabled prescaler emits none.
- R3: Channel n has a window at 0x100 + 0x10*n. Its control word is at +0x0: bit 0 is run, bit 1 is auto-repeat and bit 2 selects prescaler B (set) or prescaler A (clear).
- R4: The count is at +0x8 and is read-only. It becomes 0 when run goes from 0 to 1 and advances by one on each pulse of the selected prescaler while run is set. It holds while run is clear, and writing an unchanged run bit does not restart it.
- R5: Single-shot mode (auto-repeat clear): on a pulse while the count equals the target at +0x4, the channel sets its status bit and clears run, and the count holds at the target.
- R6: Auto-repeat mode: on a pulse while the count equals the target, the channel sets its status bit, loads the count from the reload value at +0xC, and keeps running.
- R7: The status register is at 0x10, with bit n for channel n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: When a channel event and a write clearing the same status bit fall in the same cycle, the bit ends up set.
- R9: The global enable mask is at 0x00 and the routing mask is at 0x20, each with one bit per channel. `irq_o` is high exactly when some channel has its status, enable and routing bits all set.
- R10: Reads from unmapped or misaligned addresses, and from windows of channels beyond the bank size, return 0. Writes to them change nothing.
- R11: `rdata_o` carries the addressed register one cycle after `rd_en_i` and holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle: a channel reaching its target and a status write that clears the same bit. The bench starts a single-shot channel with a target of 0 and drives one base tick together with the clearing write on one clock edge, so the event and the clear collide. It then reads the status register and expects the bit set. It also issues a clear with no tick and expects the bit to fall, which shows the clear path works on its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned PRE_W      = 8;
  localparam int unsigned OFF_IEN    = 'h00;
  localparam int unsigned OFF_STS    = 'h10;
  localparam int unsigned OFF_ROUTE  = 'h20;
  localparam int unsigned OFF_PRE    = 'h30;
  localparam int unsigned CH_BASE    = 'h100;
  localparam int unsigned CH_STRIDE  = 'h10;
  localparam int unsigned PRE_B_LSB  = 8;
  localparam int unsigned PRE_ENA    = 16;
  localparam int unsigned PRE_ENB    = 17;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_TGT  = 2'd1,
    SLOT_CNT  = 2'd2,
    SLOT_RLD  = 2'd3
  } slot_e;

  typedef struct packed {
    logic use_b;
    logic repeat_m;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  input  logic         tick_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap    = (cnt_q >= ratio_i);
  assign pulse_o = en_i & tick_i & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2: after an emitted pulse the phase counter restarts
  a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_a_i,
  input  logic             pulse_b_i,
  input  logic             ctrl_we_i,
  input  logic             tgt_we_i,
  input  logic             rld_we_i,
  input  tmr_ctrl_t        ctrl_wd_i,
  input  logic [CNT_W-1:0] val_wd_i,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] tgt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             hit_o
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cnt_q, tgt_q, rld_q;
  logic             step, start;

  assign step  = ctrl_q.run & (ctrl_q.use_b ? pulse_b_i : pulse_a_i);
  assign hit_o = step & (cnt_q == tgt_q);
  assign start = ctrl_we_i & ctrl_wd_i.run & ~ctrl_q.run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (ctrl_we_i)                        ctrl_q     <= ctrl_wd_i;
      else if (hit_o && !ctrl_q.repeat_m)   ctrl_q.run <= 1'b0;
      if (tgt_we_i) tgt_q <= val_wd_i;
      if (rld_we_i) rld_q <= val_wd_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (hit_o) cnt_q <= ctrl_q.repeat_m ? rld_q : cnt_q;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign tgt_o  = tgt_q;
  assign rld_o  = rld_q;

  // R4: a fresh run always begins at zero
  a_r4_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.run) |-> (cnt_q == '0));
  // R5: single-shot match halts the channel and freezes the count
  a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctrl_q.repeat_m && !ctrl_we_i) |=> (!ctrl_q.run && $stable(cnt_q)));
  // R6: auto-repeat match reloads and keeps running
  a_r6_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ctrl_q.repeat_m && !ctrl_we_i) |=> (ctrl_q.run && cnt_q == $past(rld_q)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned CH_END = CH_BASE + CH_STRIDE * NCH;

  logic [NCH-1:0]   ien_q, route_q, sts_q, evt, clr, ch_sel;
  logic [PRE_W-1:0] ratio_a_q, ratio_b_q;
  logic             en_a_q, en_b_q, pulse_a, pulse_b;
  logic             aligned, in_ch, sel_ien, sel_sts, sel_route, sel_pre;
  logic [ADDR_W-1:0] ch_idx;
  slot_e            slot;
  logic [BUS_W-1:0] rmux, rdata_q;

  tmr_ctrl_t        ch_ctrl [NCH];
  logic [CNT_W-1:0] ch_cnt  [NCH];
  logic [CNT_W-1:0] ch_tgt  [NCH];
  logic [CNT_W-1:0] ch_rld  [NCH];

  // address decode
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign sel_ien   = aligned && addr_i == ADDR_W'(OFF_IEN);
  assign sel_sts   = aligned && addr_i == ADDR_W'(OFF_STS);
  assign sel_route = aligned && addr_i == ADDR_W'(OFF_ROUTE);
  assign sel_pre   = aligned && addr_i == ADDR_W'(OFF_PRE);
  assign in_ch     = aligned && addr_i >= ADDR_W'(CH_BASE) && addr_i < ADDR_W'(CH_END);
  assign ch_idx    = (addr_i - ADDR_W'(CH_BASE)) >> 4;
  assign slot      = slot_e'(addr_i[3:2]);

  // shared prescalers
  tmr_prescaler #(.W(PRE_W)) u_pre_a (
    .clk(clk), .rst_n(rst_n), .en_i(en_a_q), .ratio_i(ratio_a_q),
    .tick_i(tick_i), .pulse_o(pulse_a));
  tmr_prescaler #(.W(PRE_W)) u_pre_b (
    .clk(clk), .rst_n(rst_n), .en_i(en_b_q), .ratio_i(ratio_b_q),
    .tick_i(tick_i), .pulse_o(pulse_b));

  // channel array
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_sel[n] = in_ch && (ch_idx == ADDR_W'(n));
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_a_i (pulse_a),
      .pulse_b_i (pulse_b),
      .ctrl_we_i (wr_en_i && ch_sel[n] && slot == SLOT_CTRL),
      .tgt_we_i  (wr_en_i && ch_sel[n] && slot == SLOT_TGT),
      .rld_we_i  (wr_en_i && ch_sel[n] && slot == SLOT_RLD),
      .ctrl_wd_i (tmr_ctrl_t'(wdata_i[2:0])),
      .val_wd_i  (wdata_i[CNT_W-1:0]),
      .ctrl_o    (ch_ctrl[n]),
      .cnt_o     (ch_cnt[n]),
      .tgt_o     (ch_tgt[n]),
      .rld_o     (ch_rld[n]),
      .hit_o     (evt[n])
    );
  end

  // global registers
  assign clr = (wr_en_i && sel_sts) ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q     <= '0;
      route_q   <= '0;
      sts_q     <= '0;
      ratio_a_q <= '0;
      ratio_b_q <= '0;
      en_a_q    <= 1'b0;
      en_b_q    <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt;
      if (wr_en_i && sel_ien)   ien_q   <= wdata_i[NCH-1:0];
      if (wr_en_i && sel_route) route_q <= wdata_i[NCH-1:0];
      if (wr_en_i && sel_pre) begin
        ratio_a_q <= wdata_i[PRE_W-1:0];
        ratio_b_q <= wdata_i[PRE_B_LSB +: PRE_W];
        en_a_q    <= wdata_i[PRE_ENA];
        en_b_q    <= wdata_i[PRE_ENB];
      end
    end
  end

  assign irq_o = |(sts_q & ien_q & route_q);

  // read path
  always_comb begin
    rmux = '0;
    if (sel_ien)   rmux = BUS_W'(ien_q);
    if (sel_sts)   rmux = BUS_W'(sts_q);
    if (sel_route) rmux = BUS_W'(route_q);
    if (sel_pre) begin
      rmux[PRE_W-1:0]            = ratio_a_q;
      rmux[PRE_B_LSB +: PRE_W]   = ratio_b_q;
      rmux[PRE_ENA]              = en_a_q;
      rmux[PRE_ENB]              = en_b_q;
    end
    for (int n = 0; n < NCH; n++) begin
      if (ch_sel[n]) begin
        unique case (slot)
          SLOT_CTRL: rmux = BUS_W'(ch_ctrl[n]);
          SLOT_TGT:  rmux = BUS_W'(ch_tgt[n]);
          SLOT_CNT:  rmux = BUS_W'(ch_cnt[n]);
          SLOT_RLD:  rmux = BUS_W'(ch_rld[n]);
          default:   rmux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rmux;
  end
  assign rdata_o = rdata_q;

  // R8: an event always leaves its status bit set, clear or not
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));
  // R7: a clearing write with no competing event drops the bits
  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_sts && evt == '0) |=> ((sts_q & $past(wdata_i[NCH-1:0])) == '0));
  // R9: no routing means no interrupt
  a_r9_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |-> !irq_o);
  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  localparam int NCH = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  tmr_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o));

  function automatic logic [11:0] ca(int n, int s);
    return 12'(256 + 16 * n + 4 * s);
  endfunction

  // expected channel state after n base ticks with ratio field d
  function automatic void model(input int n, d, tgt, rep, rld,
                                output int c, output int ev, output int run);
    c = 0; ev = 0; run = 1;
    for (int i = 1; i <= n; i++) begin
      if (i % (d + 1) == 0 && run == 1) begin
        if (c == tgt) begin
          ev = 1;
          if (rep != 0) c = rld; else run = 0;
        end else c++;
      end
    end
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, held;
    int c, ev, run;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, v); chk("R1 ien", v, 0);
    rd(12'h010, v); chk("R1 status", v, 0);
    rd(12'h020, v); chk("R1 route", v, 0);
    rd(12'h030, v); chk("R1 prescaler", v, 0);
    rd(ca(1, 0), v); chk("R1 ctrl", v, 0);
    rd(ca(1, 3), v); chk("R1 reload", v, 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R10 unmapped space
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    wr(ca(NCH, 0), 32'h7);
    rd(12'h000, v); chk("R10 ien untouched", v, 0);
    rd(12'h010, v); chk("R10 status untouched", v, 0);
    rd(12'h040, v); chk("R10 unmapped read", v, 0);
    rd(ca(NCH, 0), v); chk("R10 beyond bank", v, 0);
    rd(12'h031, v); chk("R10 misaligned", v, 0);

    for (int n = 0; n < NCH; n++) wr(ca(n, 1), 1000);

    // R4 counting, read-only count, restart rules
    wr(12'h030, 32'h0001_0000);
    wr(ca(0, 0), 1);
    ticks(3);
    rd(ca(0, 2), v); chk("R4 count", v, 3);
    wr(ca(0, 2), 55);
    rd(ca(0, 2), v); chk("R4 read-only", v, 3);
    wr(ca(0, 0), 1); ticks(2);
    rd(ca(0, 2), v); chk("R4 no restart", v, 5);
    wr(ca(0, 0), 0); ticks(2);
    rd(ca(0, 2), v); chk("R4 hold when idle", v, 5);
    wr(ca(0, 0), 1);
    rd(ca(0, 2), v); chk("R4 restart zero", v, 0);

    // R2 disabled and dividing prescaler
    wr(12'h030, 0);
    wr(ca(1, 0), 1); ticks(4);
    rd(ca(1, 2), v); chk("R2 disabled", v, 0);
    wr(12'h030, 32'h0001_0002); ticks(7);
    rd(ca(1, 2), v); chk("R2 ratio 3", v, 2);

    // R3 prescaler selection
    wr(12'h030, 32'h0003_0300);
    wr(ca(2, 0), 5);
    wr(ca(0, 0), 0); wr(ca(0, 0), 1);
    ticks(8);
    rd(ca(2, 2), v); chk("R3 select B", v, 2);
    rd(ca(0, 2), v); chk("R3 select A", v, 8);
    rd(12'h030, v); chk("R2 readback", v, 32'h0003_0300);

    // R5 single-shot
    wr(ca(3, 1), 2); wr(ca(3, 0), 1); ticks(3);
    rd(12'h010, v); chk("R5 status", v, 8);
    rd(ca(3, 0), v); chk("R5 run cleared", v, 0);
    ticks(2);
    rd(ca(3, 2), v); chk("R5 count frozen", v, 2);

    // R6 auto-repeat
    wr(12'h010, 8);
    wr(ca(3, 1), 3); wr(ca(3, 3), 1); wr(ca(3, 0), 3);
    ticks(4);
    rd(ca(3, 2), v); chk("R6 reload", v, 1);
    rd(ca(3, 0), v); chk("R6 still running", v, 3);
    rd(12'h010, v); chk("R6 status", v, 8);
    ticks(3);
    rd(ca(3, 2), v); chk("R6 second cycle", v, 1);

    // R7 clear rules
    wr(ca(3, 0), 0);
    wr(12'h010, 0);
    rd(12'h010, v); chk("R7 zero write keeps", v, 8);
    wr(12'h010, 8);
    rd(12'h010, v); chk("R7 one write clears", v, 0);

    // R8 event and clear in the same cycle
    wr(ca(3, 1), 0); wr(ca(3, 0), 1);
    tick_i = 1'b1; wr(12'h010, 8); tick_i = 1'b0;
    rd(12'h010, v); chk("R8 event wins", v, 8);

    // R9 interrupt gating
    chk("R9 masked", 32'(irq_o), 0);
    wr(12'h000, 8);
    chk("R9 enable only", 32'(irq_o), 0);
    wr(12'h000, 0); wr(12'h020, 8);
    chk("R9 route only", 32'(irq_o), 0);
    wr(12'h000, 8);
    chk("R9 both", 32'(irq_o), 1);
    wr(12'h010, 8);
    chk("R9 after clear", 32'(irq_o), 0);

    // R11 read data holds
    rd(12'h020, held);
    wr(12'h020, 0); @(negedge clk);
    chk("R11 hold", rdata_o, held);

    // R2 R3 R4 R5 R6 randomized trials
    void'($urandom(32'd4242));
    for (int t = 0; t < 20; t++) begin
      int ch, d, o, sb, rep, tgt, rld, n;
      ch = $urandom % NCH; d = $urandom % 4; o = $urandom % 4;
      sb = $urandom % 2; rep = $urandom % 2;
      tgt = $urandom % 6; rld = $urandom % (tgt + 1); n = $urandom % 24;
      wr(ca(ch, 0), 0); wr(12'h030, 0); wr(12'h010, 32'(1 << ch));
      wr(ca(ch, 1), tgt); wr(ca(ch, 3), rld);
      wr(12'h030, 32'h0003_0000 | 32'((sb ? d : o) << 8) | 32'(sb ? o : d));
      wr(ca(ch, 0), 32'((sb << 2) | (rep << 1) | 1));
      ticks(n);
      model(n, d, tgt, rep, rld, c, ev, run);
      rd(ca(ch, 2), v); chk("R4 R5 R6 random count", v, c);
      rd(ca(ch, 0), v); chk("R3 R5 random ctrl", v, 32'((sb << 2) | (rep << 1) | run));
      rd(12'h010, v); chk("R2 R6 random status", 32'(v[ch]), ev);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule